// File: doc/BRIEF.md
# Descriptor Ring Index Manager

This block keeps the four ring pointers of an Ethernet DMA engine: the produce and consume positions of the receive descriptor ring and of the transmit descriptor ring. The DMA hardware moves the receive produce pointer forward as it fills descriptors, and the transmit consume pointer forward as it drains them. Software moves the other two pointers, and programs each ring's size, through a narrow register write port.

From the pointers the block derives the ring conditions. These are receive frames pending, receive overrun, transmit ring empty and transmit ring full. Transmit full leaves one slot unused, so a ring of N descriptors carries at most N-1 outstanding entries.

Two pieces of combinational logic sit beside the pointer logic. The first builds the control word of a descriptor from a buffer length and two flags. The second splits a receive status word into its length and its error flags.

Top module: `dma_ring_idx`

## Requirements
- R1: After reset, and in the cycle after `ringInit` is high, all four indices read 0 and `rxOverrun` reads 0. Ring size registers reset to `RESET_M1` and are kept across `ringInit`.
- R2: A write with `regSel`=0 stores `regData` as the receive ring size minus one. A write with `regSel`=1 does the same for the transmit ring.
- R3: Each index steps by one and returns to 0 after it reaches the stored size-minus-one of its ring.
- R4: `rxPending` is 1 exactly when the receive consume index differs from the receive produce index.
- R5: If `rxHwAdv` would move the receive produce index onto the receive consume index, the index does not move and `rxOverrun` becomes 1. `rxOverrun` then stays 1 until `ringInit`.
- R6: `txFull` is 1 when the transmit produce index equals the transmit consume index minus one, modulo the ring size. A consume index of 0 therefore compares against size-1.
- R7: `txEmpty` is 1 when the two transmit indices are equal. While it is 1, `txHwAdv` has no effect.
- R8: Software index writes (`regSel`=2 for receive consume, `regSel`=3 for transmit produce) whose value exceeds the ring's size-minus-one are ignored.
- R9: A hardware advance and a software index write on the same ring in the same cycle both take effect. `ringInit` overrides both.
- R10: `dscWord` carries `dscBytes`-1 in bits 10:0, `dscIrq` in bit 31, `dscLast` in bit 30, and zeros elsewhere.
- R11: `stsLen` equals `stsWord[10:0]`+1. `stsFlags[8:0]` equals `stsWord[31:23]`, which in order from bit 0 are: CRC error, symbol error, length error, range error, alignment error, overrun, no descriptor, last fragment, any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ringInit | input | 1 | Zero all indices and clear overrun |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | 0 rx size-1, 1 tx size-1, 2 rx consume, 3 tx produce |
| regData | input | IDX_W | Write data |
| rxHwAdv | input | 1 | Hardware filled one receive descriptor |
| txHwAdv | input | 1 | Hardware drained one transmit descriptor |
| rxProdIdx | output | IDX_W | Receive produce index |
| rxConsIdx | output | IDX_W | Receive consume index |
| txProdIdx | output | IDX_W | Transmit produce index |
| txConsIdx | output | IDX_W | Transmit consume index |
| rxPending | output | 1 | Receive frames waiting |
| rxOverrun | output | 1 | Sticky receive overrun |
| txEmpty | output | 1 | Transmit ring empty |
| txFull | output | 1 | Transmit ring full |
| dscBytes | input | LEN_W+1 | Descriptor buffer length in bytes |
| dscIrq | input | 1 | Interrupt request flag for descriptor |
| dscLast | input | 1 | Last fragment flag for descriptor |
| dscWord | output | 32 | Formatted descriptor control word |
| stsWord | input | 32 | Receive status word |
| stsLen | output | LEN_W+1 | Received length in bytes |
| stsFlags | output | 9 | Decoded status flags |

## Verification
On one ring, a hardware advance and a software pointer write can land in the same cycle. The bench provokes this on the receive ring by raising `rxHwAdv` while it rewrites the consume index. On the transmit ring it raises `txHwAdv` while it rewrites the produce index across the wrap point. The cycle after, both pointers must show their new values, and the derived pending and full flags must match the combined state. The bench also raises `ringInit` together with a hardware advance, and all indices must stay zero.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef struct packed {
    logic clrAll;
    logic rxSizeWr;
    logic txSizeWr;
    logic rxConsWr;
    logic txProdWr;
    logic rxProdInc;
    logic txConsInc;
    logic setOvr;
  } ringStrb_t;

  localparam int SEL_RX_SIZE = 0;
  localparam int SEL_TX_SIZE = 1;
  localparam int SEL_RX_CONS = 2;
  localparam int SEL_TX_PROD = 3;
endpackage

// File: rtl/ring_ctl.sv
module ring_ctl
  import ring_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ringInit,
  input  logic             regWr,
  input  logic [1:0]       regSel,
  input  logic [IDX_W-1:0] regData,
  input  logic             rxHwAdv,
  input  logic             txHwAdv,
  input  logic [IDX_W-1:0] rxProd,
  input  logic [IDX_W-1:0] rxCons,
  input  logic [IDX_W-1:0] txProd,
  input  logic [IDX_W-1:0] txCons,
  input  logic [IDX_W-1:0] rxSizeM1,
  input  logic [IDX_W-1:0] txSizeM1,
  output ringStrb_t        strb
);
  logic [IDX_W-1:0] rxNext;
  logic             rxWouldHit;

  always_comb begin
    rxNext     = (rxProd >= rxSizeM1) ? '0 : rxProd + 1'b1;
    rxWouldHit = (rxNext == rxCons);
    strb           = '0;
    strb.clrAll    = ringInit;
    strb.rxSizeWr  = !ringInit && regWr && (regSel == 2'(SEL_RX_SIZE));
    strb.txSizeWr  = !ringInit && regWr && (regSel == 2'(SEL_TX_SIZE));
    strb.rxConsWr  = !ringInit && regWr && (regSel == 2'(SEL_RX_CONS)) && (regData <= rxSizeM1);
    strb.txProdWr  = !ringInit && regWr && (regSel == 2'(SEL_TX_PROD)) && (regData <= txSizeM1);
    strb.rxProdInc = !ringInit && rxHwAdv && !rxWouldHit;
    strb.setOvr    = !ringInit && rxHwAdv && rxWouldHit;
    strb.txConsInc = !ringInit && txHwAdv && (txCons != txProd);
  end

  // R2
  cfg_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rxSizeWr, strb.txSizeWr, strb.rxConsWr, strb.txProdWr}));

  // R7
  tx_empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCons == txProd) |-> !strb.txConsInc);
endmodule

// File: rtl/ring_dp.sv
module ring_dp
  import ring_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int RESET_M1 = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrb_t        strb,
  input  logic [IDX_W-1:0] regData,
  output logic [IDX_W-1:0] rxProd,
  output logic [IDX_W-1:0] rxCons,
  output logic [IDX_W-1:0] txProd,
  output logic [IDX_W-1:0] txCons,
  output logic [IDX_W-1:0] rxSizeM1,
  output logic [IDX_W-1:0] txSizeM1,
  output logic             rxPending,
  output logic             rxOverrun,
  output logic             txEmpty,
  output logic             txFull
);
  localparam logic [IDX_W-1:0] SIZE_RST = IDX_W'(RESET_M1);

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] idx,
                                               input logic [IDX_W-1:0] lim);
    return (idx >= lim) ? '0 : idx + 1'b1;
  endfunction

  logic [IDX_W-1:0] txConsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSizeM1 <= SIZE_RST;
      txSizeM1 <= SIZE_RST;
    end else begin
      if (strb.rxSizeWr) rxSizeM1 <= regData;
      if (strb.txSizeWr) txSizeM1 <= regData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxProd    <= '0;
      rxCons    <= '0;
      txProd    <= '0;
      txCons    <= '0;
      rxOverrun <= 1'b0;
    end else if (strb.clrAll) begin
      rxProd    <= '0;
      rxCons    <= '0;
      txProd    <= '0;
      txCons    <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (strb.rxProdInc) rxProd <= stepIdx(rxProd, rxSizeM1);
      if (strb.rxConsWr)  rxCons <= regData;
      if (strb.txProdWr)  txProd <= regData;
      if (strb.txConsInc) txCons <= stepIdx(txCons, txSizeM1);
      if (strb.setOvr)    rxOverrun <= 1'b1;
    end
  end

  always_comb begin
    txConsPrev = (txCons == '0) ? txSizeM1 : txCons - 1'b1;
    rxPending  = (rxCons != rxProd);
    txEmpty    = (txCons == txProd);
    txFull     = (txProd == txConsPrev);
  end

  // R1
  init_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (rxProd == '0 && rxCons == '0 && txProd == '0 && txCons == '0 && !rxOverrun));

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !strb.clrAll) |=> rxOverrun);

  // R5
  rx_no_overtake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxProdInc && !strb.rxConsWr && !strb.rxSizeWr) |=> (rxProd != rxCons));

  // R6
  tx_drain_not_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txConsInc && !strb.txProdWr && !strb.txSizeWr) |=> !txFull);
endmodule

// File: rtl/dsc_fmt.sv
module dsc_fmt #(
  parameter int LEN_W = 11
) (
  input  logic [LEN_W:0]   dscBytes,
  input  logic             dscIrq,
  input  logic             dscLast,
  output logic [31:0]      dscWord,
  input  logic [31:0]      stsWord,
  output logic [LEN_W:0]   stsLen,
  output logic [8:0]       stsFlags
);
  localparam int FLAG_LO = 23;
  logic [LEN_W:0] bytesM1;

  always_comb begin
    bytesM1             = dscBytes - 1'b1;
    dscWord             = '0;
    dscWord[LEN_W-1:0]  = bytesM1[LEN_W-1:0];
    dscWord[31]         = dscIrq;
    dscWord[30]         = dscLast;
    stsLen              = {1'b0, stsWord[LEN_W-1:0]} + 1'b1;
    stsFlags            = stsWord[FLAG_LO +: 9];
  end

  // R10
  dsc_flag_chk: assert final (dscWord[31] == dscIrq && dscWord[30] == dscLast);
endmodule

// File: rtl/dma_ring_idx.sv
module dma_ring_idx
  import ring_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int RESET_M1 = 7,
  parameter int LEN_W    = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ringInit,
  input  logic             regWr,
  input  logic [1:0]       regSel,
  input  logic [IDX_W-1:0] regData,
  input  logic             rxHwAdv,
  input  logic             txHwAdv,
  output logic [IDX_W-1:0] rxProdIdx,
  output logic [IDX_W-1:0] rxConsIdx,
  output logic [IDX_W-1:0] txProdIdx,
  output logic [IDX_W-1:0] txConsIdx,
  output logic             rxPending,
  output logic             rxOverrun,
  output logic             txEmpty,
  output logic             txFull,
  input  logic [LEN_W:0]   dscBytes,
  input  logic             dscIrq,
  input  logic             dscLast,
  output logic [31:0]      dscWord,
  input  logic [31:0]      stsWord,
  output logic [LEN_W:0]   stsLen,
  output logic [8:0]       stsFlags
);
  ringStrb_t        strb;
  logic [IDX_W-1:0] rxSizeM1;
  logic [IDX_W-1:0] txSizeM1;

  ring_ctl #(.IDX_W(IDX_W)) ctl_i (
    .clk(clk), .rstN(rstN), .ringInit(ringInit), .regWr(regWr), .regSel(regSel),
    .regData(regData), .rxHwAdv(rxHwAdv), .txHwAdv(txHwAdv),
    .rxProd(rxProdIdx), .rxCons(rxConsIdx), .txProd(txProdIdx), .txCons(txConsIdx),
    .rxSizeM1(rxSizeM1), .txSizeM1(txSizeM1), .strb(strb)
  );

  ring_dp #(.IDX_W(IDX_W), .RESET_M1(RESET_M1)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regData(regData),
    .rxProd(rxProdIdx), .rxCons(rxConsIdx), .txProd(txProdIdx), .txCons(txConsIdx),
    .rxSizeM1(rxSizeM1), .txSizeM1(txSizeM1), .rxPending(rxPending),
    .rxOverrun(rxOverrun), .txEmpty(txEmpty), .txFull(txFull)
  );

  dsc_fmt #(.LEN_W(LEN_W)) fmt_i (
    .dscBytes(dscBytes), .dscIrq(dscIrq), .dscLast(dscLast), .dscWord(dscWord),
    .stsWord(stsWord), .stsLen(stsLen), .stsFlags(stsFlags)
  );
endmodule

// File: tb/dma_ring_idx_tb_top.sv
`timescale 1ns/1ps
module dma_ring_idx_tb_top;
  localparam int IDX_W = 4;
  localparam int LEN_W = 11;
  localparam int NVEC  = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ringInit = 1'b0, regWr = 1'b0, rxHwAdv = 1'b0, txHwAdv = 1'b0;
  logic [1:0] regSel = '0;
  logic [IDX_W-1:0] regData = '0;
  logic [IDX_W-1:0] rxProdIdx, rxConsIdx, txProdIdx, txConsIdx;
  logic rxPending, rxOverrun, txEmpty, txFull;
  logic [LEN_W:0] dscBytes = '0;
  logic dscIrq = 1'b0, dscLast = 1'b0;
  logic [31:0] dscWord;
  logic [31:0] stsWord = '0;
  logic [LEN_W:0] stsLen;
  logic [8:0] stsFlags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_ring_idx dut_i (.*);

  // rxA txA wr sel data | rP rC tP tC pend full ovr
  localparam int VEC [NVEC][12] = '{
    '{0,0,1,0,3, 0,0,0,0, 0,0,0},  // R2 rx size 4
    '{0,0,1,1,3, 0,0,0,0, 0,0,0},  // R2 tx size 4
    '{1,0,0,0,0, 1,0,0,0, 1,0,0},  // R3 R4
    '{1,0,0,0,0, 2,0,0,0, 1,0,0},
    '{1,0,0,0,0, 3,0,0,0, 1,0,0},
    '{1,0,0,0,0, 3,0,0,0, 1,0,1},  // R5 blocked
    '{0,0,1,2,2, 3,2,0,0, 1,0,1},
    '{1,0,0,0,0, 0,2,0,0, 1,0,1},  // R3 wrap
    '{1,0,1,2,1, 1,1,0,0, 0,0,1},  // R9 rx concurrent
    '{0,0,1,3,2, 1,1,2,0, 0,0,1},
    '{0,0,1,3,3, 1,1,3,0, 0,1,1},  // R6 cons 0 vs size-1
    '{0,1,0,0,0, 1,1,3,1, 0,0,1},
    '{0,1,0,0,0, 1,1,3,2, 0,0,1},
    '{0,1,0,0,0, 1,1,3,3, 0,0,1},
    '{0,1,0,0,0, 1,1,3,3, 0,0,1},  // R7 ignored when empty
    '{0,0,1,3,5, 1,1,3,3, 0,0,1},  // R8 out of range
    '{0,0,1,3,2, 1,1,2,3, 0,1,1},  // R6
    '{0,1,1,3,0, 1,1,0,0, 0,0,1}   // R9 tx concurrent, cons wraps
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic chkState(input string req, input int rp, input int rc, input int tp,
                          input int tc, input int pend, input int full, input int ovr);
    chk({req, " rxProd"}, int'(rxProdIdx), rp);
    chk({req, " rxCons"}, int'(rxConsIdx), rc);
    chk({req, " txProd"}, int'(txProdIdx), tp);
    chk({req, " txCons"}, int'(txConsIdx), tc);
    chk({req, " rxPending"}, int'(rxPending), pend);
    chk({req, " txFull"}, int'(txFull), full);
    chk({req, " rxOverrun"}, int'(rxOverrun), ovr);
    chk({req, " txEmpty"}, int'(txEmpty), int'(tp == tc));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    @(negedge clk);
    rxHwAdv = 1'b0; txHwAdv = 1'b0; regWr = 1'b0; ringInit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chkState("R1 reset", 0, 0, 0, 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      rxHwAdv = VEC[i][0][0];
      txHwAdv = VEC[i][1][0];
      regWr   = VEC[i][2][0];
      regSel  = 2'(VEC[i][3]);
      regData = IDX_W'(VEC[i][4]);
      step();
      chkState($sformatf("R3 R9 vec%0d", i), VEC[i][5], VEC[i][6], VEC[i][7],
               VEC[i][8], VEC[i][9], VEC[i][10], VEC[i][11]);
    end

    // R1 init clears and wins over a hardware advance
    ringInit = 1'b1; rxHwAdv = 1'b1; txHwAdv = 1'b1;
    step();
    chkState("R1 init", 0, 0, 0, 0, 0, 0, 0);

    // R2 size kept after init: ring of 4 wraps after 3
    for (int k = 0; k < 3; k++) begin
      rxHwAdv = 1'b1;
      step();
    end
    chk("R2 kept rxProd", int'(rxProdIdx), 3);
    rxHwAdv = 1'b1;
    step();
    chk("R5 overrun after init", int'(rxOverrun), 1);
    chk("R5 blocked", int'(rxProdIdx), 3);

    // R10 descriptor control word
    dscBytes = 12'd1536; dscIrq = 1'b1; dscLast = 1'b0;
    #1;
    chk("R10 word irq", int'(dscWord), int'(32'h8000_05FF));
    dscBytes = 12'd1; dscIrq = 1'b0; dscLast = 1'b1;
    #1;
    chk("R10 word last", int'(dscWord), int'(32'h4000_0000));

    // R11 status decode
    stsWord = 32'h8080_003F;
    #1;
    chk("R11 len", int'(stsLen), 64);
    chk("R11 flags", int'(stsFlags), 9'h101);
    stsWord = 32'h4100_07FF;
    #1;
    chk("R11 len max", int'(stsLen), 2048);
    chk("R11 flags sym last", int'(stsFlags), 9'h082);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog got=0 exp=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule